// File: doc/BRIEF.md
# Clock-Out and Countdown Timer Prescaler

This block takes a one-cycle enable that pulses at the 32.768 kHz reference rate and runs it through one free-running binary divider chain. That chain serves two consumers.

The first is a gated clock output. It can run at the full reference rate, at 1024 Hz, at 32 Hz or at 1 Hz. The second is an 8-bit countdown timer. Its decrement strobe can run at 4096 Hz, 64 Hz, 1 Hz or once a minute. The once-a-minute strobe comes from dividing the 1 Hz strobe by a further counter.

Each time the countdown expires, the block latches a timer flag and reloads the count. It can also drive an active-low interrupt, either as a level that follows the flag or as a pulse that lasts one source period.

A host reaches the block through a byte-wide register port. Writes take effect on the clock edge. Reads return their data combinationally from the address. The register addresses are parameters of a larger register file, and the defaults place them at 0x01 (interrupt control), 0x0D (clock-out), 0x0E (timer control) and 0x0F (count).

The chain width `DIV_W` sets the reference: a strobe period of 2^k ticks stands for 2^(15-k)·1 Hz at the default of 15. `MIN_DIV` (default 60) sets the 1 Hz to minute ratio.

Top module: `presc_timer`

## Requirements
- R1: After reset every register reads 0, `clk_out` is low and `tmr_irq_n` is high.
- R2: Bits 1:0 of register 0x0D choose the clock output. Code 0 passes `ref_tick` through, giving one high cycle per reference tick. Code 1 gives a square wave with a period of 2^(DIV_W-10) ticks (1024 Hz). Code 2 gives a period of 2^(DIV_W-5) ticks (32 Hz). Code 3 gives a period of 2^DIV_W ticks (1 Hz).
- R3: When bit 7 of register 0x0D is 0, `clk_out` is held low whatever the rate code.
- R4: Bit 7 of register 0x0E enables the timer. Bits 1:0 choose the decrement strobe period: code 0 is 2^(DIV_W-12) ticks (4096 Hz), code 1 is 2^(DIV_W-6) ticks (64 Hz), code 2 is 2^DIV_W ticks (1 Hz), and code 3 is MIN_DIV·2^DIV_W ticks (1 Hz divided by MIN_DIV).
- R5: Writing N to register 0x0F sets both the reload value and the live count to N. The count drops by one per strobe, expires on the N-th strobe and then restarts from N. Reading 0x0F returns the live count.
- R6: While the timer is disabled, or while the reload value is 0, the count does not change and the flag is not set.
- R7: Register 0x01 holds the interrupt enable in bit 0, the timer flag in bit 2 and the interrupt mode in bit 4; its other bits read 0. The flag sets on every expiry, whether or not the interrupt is enabled. A write with bit 2 = 0 clears the flag, and a write with bit 2 = 1 leaves it unchanged.
- R8: In level mode (bit 4 = 0) with the interrupt enabled, `tmr_irq_n` is low exactly while the flag is set.
- R9: In pulse mode (bit 4 = 1) with the interrupt enabled, `tmr_irq_n` falls on an expiry and rises at the next decrement strobe. The flag still latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable at the reference rate |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address for reads and writes |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| clk_out | output | 1 | Gated, rate-selected clock output |
| tmr_irq_n | output | 1 | Active-low timer interrupt |

## Verification
The bench measures the expiry latency after a count write to the cycle, and reads the count in the very cycle the flag appears. A countdown that expired one strobe early or late, or that reloaded to zero, would therefore be caught. It measures both the low time and the fall-to-fall interval of the pulsed interrupt for three source rates, including the minute divider. A pulse stretched to the flag's lifetime, or a minute stage miscounted, would show up as a wrong interval. It also confirms that the flag still latches with the interrupt masked, that a write with the flag bit set leaves the flag in place, and that a count of zero or a disabled timer leaves the count frozen. A design that treated the flag as a plain register, or that counted down regardless of enable, would fail those checks.

// File: rtl/presc_pkg.sv
package presc_pkg;
   localparam int BYTE_W = 8;
   localparam int ADR_W  = 4;

   // register addresses within the host byte map
   localparam logic [ADR_W-1:0] A_IRQ_CTL = 4'h1;
   localparam logic [ADR_W-1:0] A_CLKO    = 4'hD;
   localparam logic [ADR_W-1:0] A_TMR_CTL = 4'hE;
   localparam logic [ADR_W-1:0] A_TMR_CNT = 4'hF;

   // bit positions
   localparam int B_IE    = 0;
   localparam int B_FLAG  = 2;
   localparam int B_PULSE = 4;
   localparam int B_ON    = 7;

   typedef logic [1:0] rate_code_t;
endpackage

// File: rtl/presc_chain.sv
module presc_chain #(
   parameter int DIV_W   = 15,
   parameter int MIN_DIV = 60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   output logic [3:0] src_stb,
   output logic [3:0] sq_tap
);
   localparam int MW = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;

   if (DIV_W < 12) begin : g_w_chk
      $error("presc_chain: DIV_W must be at least 12");
   end
   if (MIN_DIV < 1) begin : g_m_chk
      $error("presc_chain: MIN_DIV must be at least 1");
   end

   function automatic int stb_shift(input int code);
      case (code)
         0:       return DIV_W - 12;
         1:       return DIV_W - 6;
         default: return DIV_W;
      endcase
   endfunction

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   for (genvar g = 0; g < 3; g++) begin : g_stb
      localparam int SH = stb_shift(g);
      localparam logic [DIV_W-1:0] MSK = {DIV_W{1'b1}} >> (DIV_W - SH);
      assign src_stb[g] = tick && ((cnt & MSK) == MSK);
   end

   if (MIN_DIV > 1) begin : g_min
      logic [MW-1:0] mcnt;
      logic          mwrap;
      assign mwrap = (mcnt == MW'(MIN_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          mcnt <= '0;
         else if (src_stb[2]) mcnt <= mwrap ? '0 : mcnt + 1'b1;
      end
      assign src_stb[3] = src_stb[2] && mwrap;
   end else begin : g_nomin
      assign src_stb[3] = src_stb[2];
   end

   assign sq_tap[0] = tick;
   assign sq_tap[1] = cnt[DIV_W-11];
   assign sq_tap[2] = cnt[DIV_W-6];
   assign sq_tap[3] = cnt[DIV_W-1];
endmodule

// File: rtl/clko_mux.sv
module clko_mux (
   input  logic       gate,
   input  logic [1:0] sel,
   input  logic [3:0] taps,
   output logic       out
);
   assign out = gate & taps[sel];
endmodule

// File: rtl/cd_timer.sv
module cd_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             stb,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cur,
   output logic [CNT_W-1:0] reload,
   output logic             expire
);
   logic live;
   logic last;

   assign live   = run && stb && (reload != '0);
   assign last   = (cur <= CNT_W'(1));
   assign expire = live && last && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= '0;
         reload <= '0;
      end else if (load) begin
         cur    <= load_val;
         reload <= load_val;
      end else if (live) begin
         cur <= last ? reload : cur - 1'b1;
      end
   end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic stb,
   input  logic ctl_wr,
   input  logic keep_flag,
   input  logic ie,
   input  logic pulse_mode,
   output logic flag,
   output logic irq_n
);
   logic pulse_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag      <= 1'b0;
         pulse_act <= 1'b0;
      end else begin
         if (expire)      flag <= 1'b1;
         else if (ctl_wr) flag <= flag & keep_flag;

         if (expire)      pulse_act <= 1'b1;
         else if (stb)    pulse_act <= 1'b0;
      end
   end

   assign irq_n = !(ie && (pulse_mode ? pulse_act : flag));
endmodule

// File: rtl/presc_timer.sv
module presc_timer
   import presc_pkg::*;
#(
   parameter int DIV_W   = 15,
   parameter int MIN_DIV = 60,
   parameter int CNT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              host_we,
   input  logic [ADR_W-1:0]  host_addr,
   input  logic [BYTE_W-1:0] host_wdata,
   output logic [BYTE_W-1:0] host_rdata,
   output logic              clk_out,
   output logic              tmr_irq_n
);
   if (CNT_W < 1 || CNT_W > BYTE_W) begin : g_cnt_chk
      $error("presc_timer: CNT_W must lie in 1..8");
   end

   logic       ie, pmode, clko_gate, tmr_en;
   rate_code_t clko_sel, tmr_src;
   logic [3:0] src_stb, sq_tap;
   logic       sel_stb, sec_stb, min_stb;
   logic       expire, flag;
   logic [CNT_W-1:0] cur, reload;

   logic wr_ctl, wr_clko, wr_tctl, wr_cnt;
   assign wr_ctl  = host_we && (host_addr == A_IRQ_CTL);
   assign wr_clko = host_we && (host_addr == A_CLKO);
   assign wr_tctl = host_we && (host_addr == A_TMR_CTL);
   assign wr_cnt  = host_we && (host_addr == A_TMR_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie        <= 1'b0;
         pmode     <= 1'b0;
         clko_gate <= 1'b0;
         clko_sel  <= '0;
         tmr_en    <= 1'b0;
         tmr_src   <= '0;
      end else begin
         if (wr_ctl) begin
            ie    <= host_wdata[B_IE];
            pmode <= host_wdata[B_PULSE];
         end
         if (wr_clko) begin
            clko_gate <= host_wdata[B_ON];
            clko_sel  <= host_wdata[1:0];
         end
         if (wr_tctl) begin
            tmr_en  <= host_wdata[B_ON];
            tmr_src <= host_wdata[1:0];
         end
      end
   end

   presc_chain #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ref_tick),
      .src_stb (src_stb),
      .sq_tap  (sq_tap)
   );

   assign sel_stb = src_stb[tmr_src];
   assign sec_stb = src_stb[2];
   assign min_stb = src_stb[3];

   clko_mux u_clko (
      .gate (clko_gate),
      .sel  (clko_sel),
      .taps (sq_tap),
      .out  (clk_out)
   );

   cd_timer #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (tmr_en),
      .stb      (sel_stb),
      .load     (wr_cnt),
      .load_val (host_wdata[CNT_W-1:0]),
      .cur      (cur),
      .reload   (reload),
      .expire   (expire)
   );

   tmr_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .stb        (sel_stb),
      .ctl_wr     (wr_ctl),
      .keep_flag  (host_wdata[B_FLAG]),
      .ie         (ie),
      .pulse_mode (pmode),
      .flag       (flag),
      .irq_n      (tmr_irq_n)
   );

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         A_IRQ_CTL: begin
            host_rdata[B_IE]    = ie;
            host_rdata[B_FLAG]  = flag;
            host_rdata[B_PULSE] = pmode;
         end
         A_CLKO: begin
            host_rdata[B_ON] = clko_gate;
            host_rdata[1:0]  = clko_sel;
         end
         A_TMR_CTL: begin
            host_rdata[B_ON] = tmr_en;
            host_rdata[1:0]  = tmr_src;
         end
         A_TMR_CNT: host_rdata[CNT_W-1:0] = cur;
         default:   host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/presc_timer_chk.sv
module presc_timer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clk_out,
   input logic             tmr_irq_n,
   input logic             clko_gate,
   input logic             sel_stb,
   input logic             sec_stb,
   input logic             min_stb,
   input logic             expire,
   input logic             flag,
   input logic             tmr_en,
   input logic             pmode,
   input logic             ie,
   input logic             host_we,
   input logic [CNT_W-1:0] cur,
   input logic [CNT_W-1:0] reload
);
   // R3
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clko_gate |-> !clk_out);

   // R4
   min_in_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      min_stb |-> sec_stb);

   // R5
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cur == $past(reload)));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en && !host_we) |=> $stable(cur));

   // R7
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(sel_stb));

   // R9
   pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pmode && ie && !tmr_irq_n && !sel_stb && !host_we) |=> !tmr_irq_n);
endmodule

bind presc_timer presc_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_out   (clk_out),
   .tmr_irq_n (tmr_irq_n),
   .clko_gate (clko_gate),
   .sel_stb   (sel_stb),
   .sec_stb   (sec_stb),
   .min_stb   (min_stb),
   .expire    (expire),
   .flag      (flag),
   .tmr_en    (tmr_en),
   .pmode     (pmode),
   .ie        (ie),
   .host_we   (host_we),
   .cur       (cur),
   .reload    (reload)
);

// File: tb/tb_presc_timer.sv
`timescale 1ns/1ps
module tb_presc_timer;
   localparam int W  = 12;
   localparam int MD = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b1;
   logic       host_we = 1'b0;
   logic [3:0] host_addr = 4'h0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       clk_out;
   logic       tmr_irq_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   presc_timer #(.DIV_W(W), .MIN_DIV(MD), .CNT_W(8)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick   (ref_tick),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .clk_out    (clk_out),
      .tmr_irq_n  (tmr_irq_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int d);
      host_addr = a;
      #1;
      d = int'(host_rdata);
   endtask

   task automatic clk_period(output int p);
      int n;
      @(negedge clk);
      while (clk_out) @(negedge clk);
      while (!clk_out) @(negedge clk);
      n = 0;
      while (clk_out) begin @(negedge clk); n++; end
      while (!clk_out) begin @(negedge clk); n++; end
      p = n;
   endtask

   task automatic irq_pulse(input int exp_low, input int exp_per, input string tag);
      int lo, per;
      while (!tmr_irq_n) @(negedge clk);
      while (tmr_irq_n) @(negedge clk);
      lo = 0;
      while (!tmr_irq_n) begin @(negedge clk); lo++; end
      per = lo;
      while (tmr_irq_n) begin @(negedge clk); per++; end
      chk(lo == exp_low, {tag, " low time"}, lo, exp_low);
      chk(per == exp_per, {tag, " period"}, per, exp_per);
   endtask

   task automatic t_reset();
      int v;
      rd(4'h1, v); chk(v == 0, "R1 irq ctl reset", v, 0);
      rd(4'hD, v); chk(v == 0, "R1 clko reset", v, 0);
      rd(4'hE, v); chk(v == 0, "R1 tmr ctl reset", v, 0);
      rd(4'hF, v); chk(v == 0, "R1 count reset", v, 0);
      chk(clk_out == 1'b0, "R1 clk_out reset", int'(clk_out), 0);
      chk(tmr_irq_n == 1'b1, "R1 irq reset", int'(tmr_irq_n), 1);
   endtask

   task automatic t_clkout();
      int p, hi;
      wr(4'hD, 8'h81); clk_period(p); chk(p == 4, "R2 code1 period", p, 4);
      wr(4'hD, 8'h82); clk_period(p); chk(p == 128, "R2 code2 period", p, 128);
      wr(4'hD, 8'h83); clk_period(p); chk(p == 4096, "R2 code3 period", p, 4096);
      wr(4'hD, 8'h80);
      @(negedge clk); ref_tick = 1'b0; #1;
      chk(clk_out == 1'b0, "R2 code0 tick low", int'(clk_out), 0);
      @(negedge clk); ref_tick = 1'b1; #1;
      chk(clk_out == 1'b1, "R2 code0 tick high", int'(clk_out), 1);
      // R3 gate off with a fast rate selected
      wr(4'hD, 8'h01);
      hi = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (clk_out) hi++; end
      chk(hi == 0, "R3 gated output high samples", hi, 0);
   endtask

   task automatic t_level();
      int n, v;
      wr(4'h1, 8'h01);
      wr(4'hE, 8'h80);
      wr(4'hF, 8'd5);
      n = 0;
      while (tmr_irq_n && n < 1000) begin @(negedge clk); n++; end
      chk(n == 5, "R5 expiry after N strobes", n, 5);
      rd(4'hF, v); chk(v == 5, "R5 reload on expiry", v, 5);
      chk(tmr_irq_n == 1'b0, "R8 level irq low", int'(tmr_irq_n), 0);
      wr(4'hE, 8'h00);
      wr(4'h1, 8'h05);
      rd(4'h1, v); chk(v == 8'h05, "R7 write 1 keeps flag", v, 5);
      chk(tmr_irq_n == 1'b0, "R8 irq held with flag", int'(tmr_irq_n), 0);
      wr(4'h1, 8'h01);
      rd(4'h1, v); chk(v == 8'h01, "R7 write 0 clears flag", v, 1);
      chk(tmr_irq_n == 1'b1, "R8 irq released", int'(tmr_irq_n), 1);
   endtask

   task automatic t_masked();
      int lows, v;
      wr(4'h1, 8'h00);
      wr(4'hE, 8'h80);
      wr(4'hF, 8'd3);
      lows = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (!tmr_irq_n) lows++; end
      chk(lows == 0, "R7 masked irq stays high", lows, 0);
      rd(4'h1, v); chk(v == 8'h04, "R7 flag latches while masked", v, 4);
   endtask

   task automatic t_idle();
      int v;
      wr(4'hE, 8'h00);
      wr(4'hF, 8'd3);
      wr(4'h1, 8'h01);
      repeat (50) @(negedge clk);
      rd(4'hF, v); chk(v == 3, "R6 disabled count frozen", v, 3);
      rd(4'h1, v); chk(v == 8'h01, "R6 disabled no flag", v, 1);
      wr(4'hF, 8'd0);
      wr(4'hE, 8'h80);
      repeat (50) @(negedge clk);
      rd(4'hF, v); chk(v == 0, "R6 zero count stays", v, 0);
      rd(4'h1, v); chk(v == 8'h01, "R6 zero count no flag", v, 1);
   endtask

   task automatic t_pulse();
      int v;
      wr(4'h1, 8'h11);
      wr(4'hE, 8'h81);
      wr(4'hF, 8'd2);
      irq_pulse(64, 128, "R9 R4 64Hz source");
      rd(4'h1, v); chk(v == 8'h15, "R9 flag latches in pulse mode", v, 8'h15);
      wr(4'hE, 8'h82);
      irq_pulse(4096, 8192, "R9 R4 1Hz source");
      wr(4'hE, 8'h83);
      irq_pulse(12288, 24576, "R9 R4 minute source");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clkout();
      t_level();
      t_masked();
      t_idle();
      t_pulse();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule